// File: doc/BRIEF.md
# Legacy PC Physical Memory Router

This block takes one physical memory access per cycle, from the processor or from a bus-mastering device, and decides where it lands in a legacy PC memory map. The possible targets are main RAM, the video device that sits behind the 0xA0000–0xBFFFF window, shadow RAM copies of the option and BIOS ROM areas, the system BIOS ROM, the expansion ROM area, or no target at all. Alongside the target the block gives the index into the selected storage array, a write strobe, a write-watchpoint hit and an error flag. The RAM and ROM arrays, the video device and the interrupt controller are outside the block. A caller uses the index to address its own arrays.

Before any decode an address-line-20 gate is applied. The processor-only memory window under video memory opens to RAM according to three control bits and the processor's management mode. Each 16 KB segment of 0xC0000–0xFFFFF carries separate read and write attributes. When the installed RAM ends, writes are dropped. Reads are served from the BIOS image if they fall in the topmost BIOS-sized window of the 4 GB space, and otherwise float to all ones. The decision is registered, so results appear one cycle after the request.

Top module: `mmap_decoder`

## Requirements
- R1: When `a20_en` is 0, address bit 20 is cleared before every decode step and before the watchpoint compare. When it is 1, the address is used unchanged.
- R2: An address below `ram_size` that lies outside 0xA0000–0xFFFFF selects RAM, with the index equal to the gated address.
- R3: A processor access (`is_cpu`=1) to 0xA0000–0xBFFFF selects RAM when `smram_avail` is set and either `smram_open` is set, or `smm_active` is set while `smram_lock` is clear. Otherwise it selects VIDEO. In both cases the index equals the address. This window is decoded before the RAM size check.
- R4: A device access (`is_cpu`=0) to 0xA0000–0xBFFFF always selects VIDEO and never RAM, whatever the control bits are.
- R5: Below `ram_size`, a write to 0xC0000–0xFFFFF uses the 2-bit field at bits [2*s+1:2*s] of `attr_wr`, where s = address bits [17:14]. Value 1 selects SHADOW with the index equal to the address. Value 0 selects NONE with no write strobe. When `pci_en` is 0, every such write is discarded.
- R6: Below `ram_size`, a read of 0xC0000–0xFFFFF uses the same field of `attr_rd`. Value 1 selects SHADOW. Value 0, or `pci_en` at 0, selects ROM: BIOS with index address & (BIOS_SZ-1) for 0xE0000–0xFFFFF, and EXROM with index BIOS_SZ + (address & (EXROM_SZ-1)) for 0xC0000–0xDFFFF.
- R7: An attribute value of 2 or 3 in the field that applies to the access, with `pci_en` set, raises `rsp_err` and selects NONE.
- R8: A write at or above `ram_size`, outside the video window, selects NONE and leaves `rsp_wen` low.
- R9: A read at or above `ram_size`, outside the video window, selects BIOS with index address & (BIOS_SZ-1) when the address is at or above 2^32 − BIOS_SZ. Otherwise it selects NONE with index 0, and the read data is then all ones on every lane.
- R10: `rsp_wp_hit` is raised for a write whose gated address equals an entry i of `wp_addrs` (bits [32*i+31:32*i]) that has `wp_en[i]` set. It is never raised for a read, and the routing of the write is unaffected.
- R11: Multi-byte accesses are little-endian and carry 1 << `req_size` bytes. `rsp_err` is raised when the low 12 address bits plus the byte count exceed 4096, meaning the access crosses a 4 KB page.
- R12: Results appear one cycle after `req_valid`. `rsp_target` is one-hot with bit 0 RAM, 1 VIDEO, 2 SHADOW, 3 BIOS, 4 EXROM, 5 NONE. `rsp_wen` is high exactly for writes that select a target other than NONE. Reset clears every output to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| req_valid | input | 1 | Access request present |
| req_addr | input | 32 | Physical byte address |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | log2 of byte count (1, 2, 4, 8) |
| is_cpu | input | 1 | Access comes from the processor |
| smm_active | input | 1 | Processor is in management mode |
| a20_en | input | 1 | Address line 20 enabled |
| smram_avail | input | 1 | Management RAM present under video window |
| smram_open | input | 1 | Management RAM open to all processor accesses |
| smram_lock | input | 1 | Management RAM closed outside explicit open |
| pci_en | input | 1 | Shadow attributes in effect |
| attr_rd | input | 32 | 16 read attribute fields, 2 bits each |
| attr_wr | input | 32 | 16 write attribute fields, 2 bits each |
| ram_size | input | 32 | Installed RAM size in bytes |
| wp_addrs | input | NUM_WP*32 | Write-watchpoint addresses |
| wp_en | input | NUM_WP | Per-entry watchpoint enable |
| rsp_valid | output | 1 | Result valid |
| rsp_target | output | 6 | One-hot target select |
| rsp_index | output | 32 | Index into the selected array |
| rsp_wen | output | 1 | Write strobe for the selected target |
| rsp_wp_hit | output | 1 | Write matched a watchpoint |
| rsp_err | output | 1 | Bad attribute or page crossing |

## Verification
The bench keeps the default BIOS_SZ and EXROM_SZ of 128 KB and four watchpoint entries, and sets `ram_size` to 2 MB, and to 1 MB for the out-of-range cases. At 2 MB a stride sweep can cover every legacy region, the RAM end and the A20 alias. All sixteen combinations of the management-RAM control bits are crossed with processor and device accesses, and each of the sixteen attribute segments is driven with all four attribute values for both reads and writes. With 128 KB ROM sizes the BIOS and expansion indices start at round offsets. The top-of-space window begins at 0xFFFE0000, so the values on both sides of it are easy to work out.

// File: rtl/mmap_pkg.sv
package mmap_pkg;

  localparam int unsigned AW      = 32;
  localparam int unsigned SEG_CNT = 16;           // 256 KB legacy area / 16 KB
  localparam int unsigned TGT_W   = 6;

  typedef enum logic [2:0] {
    TGT_RAM    = 3'd0,
    TGT_VIDEO  = 3'd1,
    TGT_SHADOW = 3'd2,
    TGT_BIOS   = 3'd3,
    TGT_EXROM  = 3'd4,
    TGT_NONE   = 3'd5
  } tgt_e;

  function automatic logic [AW-1:0] gate_a20(input logic [AW-1:0] a, input logic en);
    return en ? a : (a & ~(AW'(1) << 20));
  endfunction

  // 0xA0000 .. 0xBFFFF
  function automatic logic in_vga_window(input logic [AW-1:0] a);
    return a[AW-1:17] == 15'h0005;
  endfunction

  // 0xA0000 .. 0xFFFFF
  function automatic logic in_low_hole(input logic [AW-1:0] a);
    return (a >= AW'(32'h000A_0000)) && (a <= AW'(32'h000F_FFFF));
  endfunction

  // 0xC0000 .. 0xFFFFF
  function automatic logic in_legacy_rom(input logic [AW-1:0] a);
    return a[AW-1:18] == 14'h0003;
  endfunction

  function automatic logic smram_to_ram(input logic cpu, avail, open, smm, lock);
    return cpu && avail && (open || (smm && !lock));
  endfunction

  function automatic logic crosses_page(input logic [11:0] off, input logic [1:0] sz);
    return ({1'b0, off} + (13'd1 << sz)) > 13'd4096;
  endfunction

  function automatic logic [TGT_W-1:0] tgt_onehot(input tgt_e t);
    return TGT_W'(1) << t;
  endfunction

endpackage

// File: rtl/mmap_attr_sel.sv
module mmap_attr_sel
  import mmap_pkg::*;
(
  input  logic [AW-1:0]          addr,
  input  logic [2*SEG_CNT-1:0]   attr_rd,
  input  logic [2*SEG_CNT-1:0]   attr_wr,
  output logic [1:0]             rd_attr,
  output logic [1:0]             wr_attr
);
  localparam int unsigned SEG_BITS = $clog2(SEG_CNT);

  logic [1:0] rd_fld [SEG_CNT];
  logic [1:0] wr_fld [SEG_CNT];
  logic [SEG_BITS-1:0] seg;

  genvar g;
  generate
    for (g = 0; g < SEG_CNT; g++) begin : g_fld
      assign rd_fld[g] = attr_rd[2*g +: 2];
      assign wr_fld[g] = attr_wr[2*g +: 2];
    end
  endgenerate

  assign seg     = addr[14 +: SEG_BITS];
  assign rd_attr = rd_fld[seg];
  assign wr_attr = wr_fld[seg];
endmodule

// File: rtl/mmap_wp_match.sv
module mmap_wp_match
  import mmap_pkg::*;
#(
  parameter int unsigned NUM_WP = 4
)(
  input  logic [AW-1:0]        addr,
  input  logic                 wr,
  input  logic [NUM_WP*AW-1:0] wp_addrs,
  input  logic [NUM_WP-1:0]    wp_en,
  output logic                 hit
);
  logic [NUM_WP-1:0] match;

  genvar g;
  generate
    for (g = 0; g < NUM_WP; g++) begin : g_cmp
      assign match[g] = wp_en[g] && (wp_addrs[g*AW +: AW] == addr);
    end
  endgenerate

  assign hit = wr && (|match);
endmodule

// File: rtl/mmap_route.sv
module mmap_route
  import mmap_pkg::*;
#(
  parameter logic [31:0] BIOS_SZ  = 32'h0002_0000,
  parameter logic [31:0] EXROM_SZ = 32'h0002_0000
)(
  input  logic [AW-1:0] addr,
  input  logic          wr,
  input  logic          is_cpu,
  input  logic          smm_active,
  input  logic          smram_avail,
  input  logic          smram_open,
  input  logic          smram_lock,
  input  logic          pci_en,
  input  logic [1:0]    rd_attr,
  input  logic [1:0]    wr_attr,
  input  logic [AW-1:0] ram_size,
  output tgt_e          tgt,
  output logic [AW-1:0] index,
  output logic          attr_bad
);
  localparam logic [AW-1:0] BIOS_MASK = AW'(BIOS_SZ - 1);
  localparam logic [AW-1:0] EX_MASK   = AW'(EXROM_SZ - 1);
  localparam logic [AW-1:0] TOP_BASE  = ~BIOS_MASK;

  logic [1:0] attr;
  assign attr = pci_en ? (wr ? wr_attr : rd_attr) : 2'd0;

  always_comb begin
    tgt      = TGT_NONE;
    index    = '0;
    attr_bad = 1'b0;
    if (in_vga_window(addr)) begin
      tgt   = smram_to_ram(is_cpu, smram_avail, smram_open, smm_active, smram_lock)
              ? TGT_RAM : TGT_VIDEO;
      index = addr;
    end else if (addr >= ram_size) begin
      if (!wr && addr >= TOP_BASE) begin
        tgt   = TGT_BIOS;
        index = addr & BIOS_MASK;
      end
    end else if (!in_low_hole(addr)) begin
      tgt   = TGT_RAM;
      index = addr;
    end else if (in_legacy_rom(addr)) begin
      if (attr == 2'd1) begin
        tgt   = TGT_SHADOW;
        index = addr;
      end else if (attr != 2'd0) begin
        attr_bad = 1'b1;
      end else if (!wr) begin
        if (addr[17]) begin
          tgt   = TGT_BIOS;
          index = addr & BIOS_MASK;
        end else begin
          tgt   = TGT_EXROM;
          index = AW'(BIOS_SZ) + (addr & EX_MASK);
        end
      end
    end
  end
endmodule

// File: rtl/mmap_decoder.sv
module mmap_decoder
  import mmap_pkg::*;
#(
  parameter logic [31:0] BIOS_SZ  = 32'h0002_0000,
  parameter logic [31:0] EXROM_SZ = 32'h0002_0000,
  parameter int unsigned NUM_WP   = 4
)(
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  req_valid,
  input  logic [31:0]           req_addr,
  input  logic                  req_write,
  input  logic [1:0]            req_size,
  input  logic                  is_cpu,
  input  logic                  smm_active,
  input  logic                  a20_en,
  input  logic                  smram_avail,
  input  logic                  smram_open,
  input  logic                  smram_lock,
  input  logic                  pci_en,
  input  logic [31:0]           attr_rd,
  input  logic [31:0]           attr_wr,
  input  logic [31:0]           ram_size,
  input  logic [NUM_WP*32-1:0]  wp_addrs,
  input  logic [NUM_WP-1:0]     wp_en,
  output logic                  rsp_valid,
  output logic [5:0]            rsp_target,
  output logic [31:0]           rsp_index,
  output logic                  rsp_wen,
  output logic                  rsp_wp_hit,
  output logic                  rsp_err
);
  // named internal events (observed by the checker)
  logic [AW-1:0] eff_addr;
  logic [1:0]    rd_attr, wr_attr;
  logic          attr_bad;
  logic          page_cross;
  logic          wp_hit;
  tgt_e          tgt;
  logic [AW-1:0] index;

  assign eff_addr   = gate_a20(req_addr, a20_en);
  assign page_cross = crosses_page(eff_addr[11:0], req_size);

  mmap_attr_sel i_attr (
    .addr    (eff_addr),
    .attr_rd (attr_rd),
    .attr_wr (attr_wr),
    .rd_attr (rd_attr),
    .wr_attr (wr_attr)
  );

  mmap_wp_match #(.NUM_WP(NUM_WP)) i_wp (
    .addr     (eff_addr),
    .wr       (req_write),
    .wp_addrs (wp_addrs),
    .wp_en    (wp_en),
    .hit      (wp_hit)
  );

  mmap_route #(.BIOS_SZ(BIOS_SZ), .EXROM_SZ(EXROM_SZ)) i_route (
    .addr        (eff_addr),
    .wr          (req_write),
    .is_cpu      (is_cpu),
    .smm_active  (smm_active),
    .smram_avail (smram_avail),
    .smram_open  (smram_open),
    .smram_lock  (smram_lock),
    .pci_en      (pci_en),
    .rd_attr     (rd_attr),
    .wr_attr     (wr_attr),
    .ram_size    (ram_size),
    .tgt         (tgt),
    .index       (index),
    .attr_bad    (attr_bad)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid  <= 1'b0;
      rsp_target <= '0;
      rsp_index  <= '0;
      rsp_wen    <= 1'b0;
      rsp_wp_hit <= 1'b0;
      rsp_err    <= 1'b0;
    end else begin
      rsp_valid <= req_valid;
      if (req_valid) begin
        rsp_target <= tgt_onehot(tgt);
        rsp_index  <= index;
        rsp_wen    <= req_write && (tgt != TGT_NONE);
        rsp_wp_hit <= wp_hit;
        rsp_err    <= attr_bad || page_cross;
      end
    end
  end
endmodule

// File: rtl/mmap_decoder_chk.sv
module mmap_decoder_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic [31:0] req_addr,
  input logic        req_write,
  input logic        is_cpu,
  input logic        a20_en,
  input logic [31:0] ram_size,
  input logic        attr_bad,
  input logic        rsp_valid,
  input logic [5:0]  rsp_target,
  input logic        rsp_wen,
  input logic        rsp_wp_hit,
  input logic        rsp_err
);
  // R12
  tgt_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $countones(rsp_target) == 1);

  // R12
  idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R12
  wen_target_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !rsp_wen);

  // R4
  dev_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !is_cpu && req_addr[31:17] == 15'h0005) |=> !rsp_target[0]);

  // R8
  oor_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && a20_en && req_addr >= ram_size &&
     req_addr[31:17] != 15'h0005) |=> !rsp_wen);

  // R10
  wp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> !rsp_wp_hit);

  // R7
  attr_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && attr_bad) |=> (rsp_err && rsp_target[5] && !rsp_wen));
endmodule

bind mmap_decoder mmap_decoder_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_valid  (req_valid),
  .req_addr   (req_addr),
  .req_write  (req_write),
  .is_cpu     (is_cpu),
  .a20_en     (a20_en),
  .ram_size   (ram_size),
  .attr_bad   (attr_bad),
  .rsp_valid  (rsp_valid),
  .rsp_target (rsp_target),
  .rsp_wen    (rsp_wen),
  .rsp_wp_hit (rsp_wp_hit),
  .rsp_err    (rsp_err)
);

// File: tb/test_mmap_decoder.sv
`timescale 1ns/1ps
module test_mmap_decoder;
  localparam int NWP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, is_cpu = 1'b1, smm_active = 1'b0;
  logic a20_en = 1'b1, smram_avail = 1'b0, smram_open = 1'b0, smram_lock = 1'b0;
  logic pci_en = 1'b1;
  logic [1:0]  req_size = 2'd0;
  logic [31:0] req_addr = '0, attr_rd = '0, attr_wr = '0, ram_size = 32'h0020_0000;
  logic [NWP*32-1:0] wp_addrs = '0;
  logic [NWP-1:0]    wp_en = '0;
  logic rsp_valid, rsp_wen, rsp_wp_hit, rsp_err;
  logic [5:0]  rsp_target;
  logic [31:0] rsp_index;

  int tests = 0, fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  mmap_decoder i_mmap_decoder (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
    .req_write(req_write), .req_size(req_size), .is_cpu(is_cpu),
    .smm_active(smm_active), .a20_en(a20_en), .smram_avail(smram_avail),
    .smram_open(smram_open), .smram_lock(smram_lock), .pci_en(pci_en),
    .attr_rd(attr_rd), .attr_wr(attr_wr), .ram_size(ram_size),
    .wp_addrs(wp_addrs), .wp_en(wp_en), .rsp_valid(rsp_valid),
    .rsp_target(rsp_target), .rsp_index(rsp_index), .rsp_wen(rsp_wen),
    .rsp_wp_hit(rsp_wp_hit), .rsp_err(rsp_err)
  );

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // one access; expected values from the requirement text
  task automatic acc(input logic [31:0] addr, input logic wr, input logic cpu,
                     input logic [1:0] sz, input string tag);
    logic [31:0] a, idx;
    logic [5:0]  tg;
    logic        er, hit;
    int          seg, at;
    a   = a20_en ? addr : {addr[31:21], 1'b0, addr[19:0]};
    er  = (int'(a[11:0]) + (1 << sz)) > 4096;                        // R11
    idx = 32'h0;
    tg  = 6'b100000;
    if (a >= 32'h000A_0000 && a < 32'h000C_0000) begin              // R3 R4
      idx = a;
      tg  = (cpu && smram_avail && (smram_open || (smm_active && !smram_lock)))
            ? 6'b000001 : 6'b000010;
    end else if (a >= ram_size) begin                                // R8 R9
      if (!wr && a >= 32'hFFFE_0000) begin
        tg = 6'b001000; idx = a - 32'hFFFE_0000;
      end
    end else if (a < 32'h000A_0000 || a > 32'h000F_FFFF) begin       // R2
      tg = 6'b000001; idx = a;
    end else begin                                                   // R5 R6 R7
      seg = int'((a - 32'h000C_0000) / 32'h4000);
      at  = pci_en ? int'(((wr ? attr_wr : attr_rd) >> (2*seg)) & 32'h3) : 0;
      if (at == 1) begin tg = 6'b000100; idx = a; end
      else if (at > 1) er = 1'b1;
      else if (!wr) begin
        if (a >= 32'h000E_0000) begin tg = 6'b001000; idx = a - 32'h000E_0000; end
        else begin tg = 6'b010000; idx = 32'h0002_0000 + (a - 32'h000C_0000); end
      end
    end
    hit = 1'b0;
    for (int i = 0; i < NWP; i++)
      if (wr && wp_en[i] && wp_addrs[32*i +: 32] == a) hit = 1'b1;   // R10
    req_valid = 1'b1; req_addr = addr; req_write = wr; is_cpu = cpu; req_size = sz;
    @(posedge clk); #1;
    check($sformatf("%s R12 result a=%h wr=%0d", tag, addr, wr),
          {24'h0, rsp_valid, rsp_target, rsp_index, rsp_wen, rsp_wp_hit, rsp_err},
          {24'h0, 1'b1, tg, idx, wr && (tg != 6'b100000), hit, er});
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R12 reset outputs", {58'h0, rsp_valid, rsp_target[0], rsp_wen, rsp_wp_hit, rsp_err, |rsp_index},
          64'h0);
    check("R12 reset target", {58'h0, rsp_target}, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);

    // R2 R5 R6 R8 R9: stride sweep across the low 4 MB, shadow on everywhere
    attr_rd = 32'h5555_5555; attr_wr = 32'h5555_5555;
    for (int i = 0; i < 128; i++)
      for (int w = 0; w < 2; w++)
        acc(32'h8000 * i + 32'h10, w[0], 1'b1, 2'd2, "R2 R8 sweep");

    // R3 R4: all control-bit combinations, both sources, both ends of the window
    for (int m = 0; m < 16; m++) begin
      {smram_avail, smram_open, smm_active, smram_lock} = m[3:0];
      for (int c = 0; c < 2; c++)
        for (int w = 0; w < 2; w++) begin
          acc(32'h000A_0000, w[0], c[0], 2'd0, "R3 R4 window");
          acc(32'h000B_FFF8, w[0], c[0], 2'd3, "R3 R4 window");
        end
    end
    {smram_avail, smram_open, smm_active, smram_lock} = 4'b0;

    // R5 R6 R7: uniform attributes, every segment, with and without pci_en
    for (int p = 0; p < 2; p++) begin
      pci_en = p[0];
      for (int v = 0; v < 4; v++) begin
        attr_rd = {16{v[1:0]}};
        attr_wr = {16{v[1:0] + 2'd1}};
        for (int s = 0; s < 16; s++)
          for (int w = 0; w < 2; w++)
            acc(32'h000C_0000 + 32'h4000 * s + 32'h120, w[0], 1'b1, 2'd1, "R5 R6 R7 attr");
      end
    end
    pci_en = 1'b1;
    // R5 R6: mixed per-segment pattern, field picked by address bits [17:14]
    attr_rd = 32'h1144_4011; attr_wr = 32'h4104_1014;
    for (int s = 0; s < 16; s++)
      for (int w = 0; w < 2; w++)
        acc(32'h000C_3FFF + 32'h4000 * s, w[0], 1'b1, 2'd0, "R5 R6 mixed");

    // R8 R9: beyond 1 MB of RAM, top window edges
    ram_size = 32'h0010_0000;
    acc(32'hFFFE_0000, 1'b0, 1'b1, 2'd2, "R9 top base");
    acc(32'hFFFF_FFF0, 1'b0, 1'b1, 2'd2, "R9 top end");
    acc(32'hFFFD_FFF0, 1'b0, 1'b1, 2'd2, "R9 below top");
    acc(32'h4000_0000, 1'b0, 0, 2'd0, "R9 hole");
    acc(32'h0010_0000, 1'b0, 1'b1, 2'd0, "R9 ram end");
    acc(32'h000F_FFFF, 1'b1, 1'b1, 2'd0, "R8 last below");
    acc(32'hFFFF_0000, 1'b1, 1'b1, 2'd0, "R8 top write");
    acc(32'h0010_0000, 1'b1, 1'b1, 2'd0, "R8 ram end write");
    ram_size = 32'h0020_0000;

    // R1: A20 gate
    a20_en = 1'b0;
    acc(32'h0010_0040, 1'b0, 1'b1, 2'd0, "R1 alias low");
    acc(32'h001A_0000, 1'b1, 1'b1, 2'd0, "R1 alias window");
    acc(32'h001F_0000, 1'b0, 1'b1, 2'd0, "R1 alias rom");
    a20_en = 1'b1;
    acc(32'h0010_0040, 1'b0, 1'b1, 2'd0, "R1 gate open");

    // R10: watchpoints, entry 3 disabled
    wp_addrs = {32'h0000_0300, 32'h0000_0300, 32'h000C_4000, 32'h0000_1234};
    wp_addrs[127:96] = 32'h0000_0500;
    wp_en = 4'b0111;
    acc(32'h0000_1234, 1'b1, 1'b1, 2'd1, "R10 hit0");
    acc(32'h000C_4000, 1'b1, 1'b1, 2'd0, "R10 hit shadow");
    acc(32'h0000_0300, 1'b0, 1'b1, 2'd0, "R10 read");
    acc(32'h0000_0500, 1'b1, 1'b1, 2'd0, "R10 disabled");
    acc(32'h0000_1235, 1'b1, 1'b1, 2'd0, "R10 near miss");
    a20_en = 1'b0;
    acc(32'h0010_1234, 1'b1, 1'b1, 2'd0, "R10 R1 gated hit");
    a20_en = 1'b1;

    // R11: page crossing
    for (int z = 0; z < 4; z++) begin
      acc(32'h0000_0FFF, 1'b0, 1'b1, z[1:0], "R11 last byte");
      acc(32'h0000_1FF8, 1'b1, 1'b1, z[1:0], "R11 aligned end");
      acc(32'h0000_2FFB, 1'b0, 1'b1, z[1:0], "R11 straddle");
    end

    // R12: idle cycle drops valid
    req_valid = 1'b0;
    @(posedge clk); #1;
    check("R12 idle valid", {63'h0, rsp_valid}, 64'h0);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule